// File: doc/BRIEF.md
# Processor Tick Timer

The tick timer is a per-core timebase with two software-visible registers: a 32-bit count and a control word. The control word holds a period, an interrupt-enable bit, a sticky interrupt-pending bit and a two-bit mode. Each cycle in which the tick-enable input is high advances the count by one while the timer is running. A divider outside the block produces this enable, for example at 20 MHz, which is one count every 50 ns.

A match occurs on a tick when the low period field of the incremented count equals the programmed period. The bits of the count above that field take no part in the compare. The field wraps, so a period at or below the current field value matches only after the field rolls over. On a match the selected mode decides what happens to the count:

- Restart sets the count to zero.
- One-shot leaves the count at the matched value and halts it.
- Continuous lets the count run on.

With interrupts enabled, a match also sets the pending bit. The interrupt output follows the pending bit.

Software reaches both registers through a single-cycle register port. Writes are synchronous and reads are combinational.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0 and `irq` is low.
- R2: Writing address 0 loads the count and writing address 1 loads the control word. Reading either address returns the current value. The control word layout is: period in bits 27:0, pending in bit 28, enable in bit 29, mode in bits 31:30.
- R3: While the mode is non-zero and the timer is not halted, the count increases by exactly one in each cycle with `tick_en` high. It holds in cycles with `tick_en` low.
- R4: A match is detected when bits 27:0 of the incremented count equal the period. Count bits 31:28 are ignored by the compare.
- R5: If the period is at or below the current bits 27:0, the match happens only after those bits roll over through zero.
- R6: On a match with the enable bit (29) set, the pending bit (28) becomes 1 and `irq` goes high. With the enable bit clear, a match leaves pending at 0.
- R7: Pending is sticky. A control write with bit 28 = 0 clears it. A control write with bit 28 = 1 neither clears it nor sets it.
- R8: In mode 01 (restart), a match sets the count to 0.
- R9: In mode 10 (one-shot), a match leaves the count at the matched value and stops all further counting. Any later control write with a non-zero mode resumes counting.
- R10: In mode 11 (continuous), the count keeps incrementing through a match.
- R11: In mode 00 (disabled), ticks do not change the count and never set pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count enable, one pulse per timer tick |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = count, 1 = control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Interrupt request, equal to the pending bit |

## Verification
The assertions assume that `tick_en` and the register-port inputs are synchronous to `clk`. They also assume that a count write in the same cycle as a tick takes priority, which is why the count properties exclude cycles with a count write.

The bench drives every input at the falling edge and changes the register port only while `tick_en` is low. As a result, no write coincides with a tick, and each expected value follows from the number of tick cycles applied.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_ONESHOT = 2'b10,
    TM_CONT    = 2'b11
  } tmode_e;

  localparam int unsigned CTRL_RSVD = 4;  // pending, enable, two mode bits
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tt_match.sv
module tt_match
  import tick_timer_pkg::*;
#(
  parameter int unsigned PER_W = 28
) (
  input  logic [PER_W-1:0] cnt_field,
  input  logic [PER_W-1:0] period,
  input  tmode_e           mode,
  input  logic             halted,
  input  logic             tick_en,
  input  logic             cnt_we,
  output logic             run,
  output logic             hit
);
  logic [PER_W-1:0] field_inc;

  always_comb begin
    run       = (mode != TM_OFF) && !halted;
    field_inc = cnt_field + 1'b1;
    hit       = run && tick_en && !cnt_we && (field_inc == period);
  end
endmodule

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
  import tick_timer_pkg::*;
#(
  parameter int unsigned PER_W = 28,
  localparam int unsigned CW   = PER_W + CTRL_RSVD
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             we,
  input  logic [CW-1:0]    wdata,
  input  logic             hit,
  output logic [PER_W-1:0] period,
  output logic             ie,
  output logic             pend,
  output tmode_e           mode,
  output logic             halted
);
  logic [PER_W-1:0] period_n;
  logic             ie_n, pend_n, halted_n, pend_en, halt_en;
  tmode_e           mode_n;

  always_comb begin
    period_n = wdata[PER_W-1:0];
    ie_n     = wdata[PER_W+1];
    mode_n   = tmode_e'(wdata[PER_W+3:PER_W+2]);
    // Software can only clear pending; a match with enable sets it.
    pend_n   = (we ? (pend & wdata[PER_W]) : pend) | (hit & ie);
    pend_en  = we | (hit & ie);
    halt_en  = we | (hit && mode == TM_ONESHOT);
    halted_n = we ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      period <= '0;
      ie     <= 1'b0;
      mode   <= TM_OFF;
    end else if (we) begin
      period <= period_n;
      ie     <= ie_n;
      mode   <= mode_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      pend <= 1'b0;
    else if (pend_en) pend <= pend_n;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      halted <= 1'b0;
    else if (halt_en) halted <= halted_n;
  end

  // R6
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend && !$past(pend)) |-> $past(hit && ie));

  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(pend) && !pend) |-> $past(we && !wdata[PER_W]));

  // R9
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && mode == TM_ONESHOT && !we) |=> halted);
endmodule

// File: rtl/tt_count.sv
module tt_count
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PER_W = 28
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick_en,
  input  logic             run,
  input  logic             hit,
  input  tmode_e           mode,
  input  logic [PER_W-1:0] period,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_n;
  logic             count_en;

  always_comb begin
    count_en = we | (run & tick_en);
    if (we)                            count_n = wdata;
    else if (hit && mode == TM_RESTART) count_n = '0;
    else                               count_n = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       count <= '0;
    else if (count_en) count <= count_n;
  end

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && mode == TM_RESTART) |=> (count == '0));

  // R9
  oneshot_field_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && mode == TM_ONESHOT) |=> (count[PER_W-1:0] == $past(period)));

  // R10
  cont_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && mode == TM_CONT) |=> (count == $past(count) + 1'b1));

  // R11
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == TM_OFF && !we) |=> $stable(count));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick_en && !we) |=> $stable(count));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  localparam int unsigned PER_W = CNT_W - CTRL_RSVD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  logic             rst_i;
  logic             cnt_we, ctrl_we;
  logic [CNT_W-1:0] count;
  logic [PER_W-1:0] period;
  logic             ie, pend, halted, run, hit;
  tmode_e           mode;

  assign cnt_we  = reg_we && !reg_addr;
  assign ctrl_we = reg_we &&  reg_addr;

  tt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_ni(rst_n), .rst_no(rst_i)
  );

  tt_match #(.PER_W(PER_W)) u_match (
    .cnt_field(count[PER_W-1:0]), .period(period), .mode(mode),
    .halted(halted), .tick_en(tick_en), .cnt_we(cnt_we),
    .run(run), .hit(hit)
  );

  tt_ctrl_reg #(.PER_W(PER_W)) u_ctrl (
    .clk(clk), .rst_ni(rst_i), .we(ctrl_we), .wdata(reg_wdata), .hit(hit),
    .period(period), .ie(ie), .pend(pend), .mode(mode), .halted(halted)
  );

  tt_count #(.CNT_W(CNT_W), .PER_W(PER_W)) u_count (
    .clk(clk), .rst_ni(rst_i), .tick_en(tick_en), .run(run), .hit(hit),
    .mode(mode), .period(period), .we(cnt_we), .wdata(reg_wdata),
    .count(count)
  );

  always_comb begin
    reg_rdata = reg_addr ? {mode, ie, pend, period} : count;
    irq       = pend;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rst_i |=> (count == '0 && !irq));
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  tick_timer dut (.*);

  always #4 clk = ~clk;

  function automatic logic [31:0] ctrl(input logic [1:0] m, input logic ie_b,
                                       input logic pd, input logic [27:0] per);
    return {m, ie_b, pd, per};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1'b0, v); chk("R1 count", v, 32'h0);
    rd(1'b1, v); chk("R1 ctrl", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rw();
    logic [31:0] v;
    wr(1'b0, 32'hDEADBEEF);
    rd(1'b0, v); chk("R2 count readback", v, 32'hDEADBEEF);
    wr(1'b1, ctrl(2'b11, 1'b1, 1'b0, 28'h0000123));
    rd(1'b1, v); chk("R2 ctrl readback", v, 32'hE0000123);
    repeat (3) @(negedge clk);
    rd(1'b0, v); chk("R3 hold with tick_en low", v, 32'hDEADBEEF);
    ticks(7);
    rd(1'b0, v); chk("R3 seven ticks", v, 32'hDEADBEF6);
    wr(1'b1, 32'h0);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(1'b0, 32'h0);
    wr(1'b1, ctrl(2'b01, 1'b1, 1'b0, 28'd5));
    ticks(4);
    rd(1'b0, v); chk("R8 before match", v, 32'd4);
    chk("R6 no irq before match", {31'b0, irq}, 32'h0);
    ticks(1);
    rd(1'b0, v); chk("R8 restart to zero", v, 32'd0);
    chk("R6 irq on match", {31'b0, irq}, 32'h1);
    rd(1'b1, v); chk("R6 pending bit", v, 32'h70000005);
    ticks(2);
    rd(1'b0, v); chk("R8 counts on after restart", v, 32'd2);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    wr(1'b1, ctrl(2'b00, 1'b1, 1'b1, 28'd5));
    chk("R7 write one keeps pending", {31'b0, irq}, 32'h1);
    wr(1'b1, ctrl(2'b00, 1'b1, 1'b0, 28'd5));
    chk("R7 write zero clears", {31'b0, irq}, 32'h0);
    wr(1'b1, ctrl(2'b00, 1'b1, 1'b1, 28'd5));
    rd(1'b1, v); chk("R7 write one does not set", v, 32'h20000005);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(1'b0, 32'h0);
    wr(1'b1, ctrl(2'b10, 1'b0, 1'b0, 28'd3));
    ticks(3);
    rd(1'b0, v); chk("R9 stop at match", v, 32'd3);
    chk("R6 no pending with enable clear", {31'b0, irq}, 32'h0);
    ticks(4);
    rd(1'b0, v); chk("R9 stays halted", v, 32'd3);
    wr(1'b1, ctrl(2'b10, 1'b0, 1'b0, 28'd3));
    ticks(2);
    rd(1'b0, v); chk("R9 resumes after mode write", v, 32'd5);
  endtask

  task automatic t_cont();
    logic [31:0] v;
    wr(1'b0, 32'h0);
    wr(1'b1, ctrl(2'b11, 1'b1, 1'b0, 28'd2));
    ticks(4);
    rd(1'b0, v); chk("R10 counts through match", v, 32'd4);
    chk("R10 irq after match", {31'b0, irq}, 32'h1);
    wr(1'b1, 32'h0);
  endtask

  task automatic t_upper_bits();
    wr(1'b0, 32'h50000000);
    wr(1'b1, ctrl(2'b11, 1'b1, 1'b0, 28'd3));
    ticks(2);
    chk("R4 no early match", {31'b0, irq}, 32'h0);
    ticks(1);
    chk("R4 field match ignores upper bits", {31'b0, irq}, 32'h1);
    wr(1'b1, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(1'b0, 32'h0FFFFFFE);
    wr(1'b1, ctrl(2'b01, 1'b1, 1'b0, 28'd1));
    ticks(2);
    rd(1'b0, v); chk("R5 rolled over", v, 32'h10000000);
    chk("R5 no match before wrap", {31'b0, irq}, 32'h0);
    ticks(1);
    rd(1'b0, v); chk("R5 match after wrap restarts", v, 32'h0);
    chk("R5 irq after wrap", {31'b0, irq}, 32'h1);
    wr(1'b1, 32'h0);
  endtask

  task automatic t_off();
    logic [31:0] v;
    wr(1'b0, 32'h0);
    wr(1'b1, ctrl(2'b00, 1'b1, 1'b0, 28'd1));
    ticks(5);
    rd(1'b0, v); chk("R11 count holds when disabled", v, 32'h0);
    chk("R11 no pending when disabled", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rw();
    t_restart();
    t_sticky();
    t_oneshot();
    t_cont();
    t_upper_bits();
    t_wrap();
    t_off();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule